// File: doc/BRIEF.md
# Auto-Scan Channel Sequencer with Gain Table

This block steers an analog input multiplexer and a programmable-gain amplifier that sit in front of an A/D converter. Software sets it up over a small register bus. It writes a 2-bit gain code for each of sixteen channels and an end channel, then sets the scan enable bit. From then on, every conversion-complete strobe does two things. It latches the converted sample together with the channel it was taken from, and it moves the multiplexer on to the next channel in ascending order. After the end channel the multiplexer wraps back to channel 0. The gain output always follows the table entry for the channel that is being presented.

Each latched result has to be read before the next conversion completes. If it is not, the pairing between results and channels can no longer be trusted. The block detects this case and raises a sticky overrun flag, which software clears by writing a one to it. Every result word also carries its channel number, so software can check alignment on its own.

Top module: `scan_seq`

## Requirements
- R1: After reset the channel output is 0, the gain output is 0, the overrun flag is 0, and the control register (address 0: bit 0 scan enable, bit 1 overrun) reads 0.
- R2: While scan is enabled, each cycle with `conv_done` high moves the channel output to the next ascending channel. The channel holds in every cycle without a strobe.
- R3: When a strobe arrives while the channel is greater than or equal to the end register (address 1, bits 3:0), the next channel is 0. With an end value of 0, the channel stays 0.
- R4: The gain output always equals the table entry for the channel being output. Entry k is written and read at address 16+k, bits 1:0.
- R5: While scan is disabled, the channel output is 0, the gain output is table entry 0, and strobes do not move the channel.
- R6: A control write that takes the enable bit from 0 to 1 restarts the scan at channel 0, whatever channel was reached before.
- R7: On each strobe the result register (address 2) captures channel and sample. Bits 15:12 hold the channel that was output during that strobe, and bits 11:0 hold `conv_data`.
- R8: A strobe sets the overrun flag when the previous result has not been read. A read of address 2 in the same cycle as a strobe counts as reading the previous result.
- R9: The overrun flag stays set until a control write with bit 1 set. A control write with bit 1 clear leaves it set.
- R10: The end register and the gain entries read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 2 consumes the result) |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_data | input | 12 | Converted sample, valid with `conv_done` |
| mux_ch | output | 4 | Channel select for the analog multiplexer |
| pga_gain | output | 2 | Gain code for the amplifier |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The scan is driven with three end values. An end of 3 exposes an off-by-one at the wrap. An end of 15 walks the full index range and checks that the wrap also happens at the counter's natural limit. An end of 0 shows that the scan can stay on a single channel. Two further cases separate an advance that depends on the enable level from one that depends on the enable edge: strobes while disabled, and a re-enable from the middle of a scan. Lowering the end value below the current channel shows that the wrap test is greater-or-equal and not strict equality. Strobes without reads, and a read that falls in the same cycle as a strobe, separate a true overrun from a read that consumes the result in time.

// File: rtl/scan_pkg.sv
package scan_pkg;
    // register offsets in the lower half of the address space
    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_END    = 1;
    localparam int unsigned REG_RESULT = 2;
    // control register bit positions
    localparam int unsigned CTRL_EN    = 0;
    localparam int unsigned CTRL_OVR   = 1;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
    import scan_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int GAIN_W = 2,
    parameter int BUS_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [$clog2(NUM_CH):0]           addr,
    input  logic [BUS_W-1:0]                  wdata,
    output logic                              en,
    output logic                              en_rise,
    output logic                              ovr_clr,
    output logic [$clog2(NUM_CH)-1:0]         end_ch,
    output logic [NUM_CH-1:0][GAIN_W-1:0]     gain_tab
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = CH_W + 1;

    typedef struct packed {
        logic                          en;
        logic [CH_W-1:0]               end_ch;
        logic [NUM_CH-1:0][GAIN_W-1:0] gain;
    } regs_t;

    regs_t r_q, r_d;
    logic  ctrl_wr, end_wr, gain_wr;
    logic  unused_wdata;

    assign unused_wdata = &{1'b0, wdata};
    assign ctrl_wr = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign end_wr  = wr_en && (addr == ADDR_W'(REG_END));
    assign gain_wr = wr_en && addr[ADDR_W-1];

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.en = wdata[CTRL_EN];
        end
        if (end_wr) begin
            r_d.end_ch = wdata[CH_W-1:0];
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (gain_wr && (addr[CH_W-1:0] == CH_W'(k))) begin
                r_d.gain[k] = wdata[GAIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_rise  = ctrl_wr && wdata[CTRL_EN] && !r_q.en;
    assign ovr_clr  = ctrl_wr && wdata[CTRL_OVR];
    assign en       = r_q.en;
    assign end_ch   = r_q.end_ch;
    assign gain_tab = r_q.gain;
endmodule

// File: rtl/scan_index.sv
module scan_index #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            restart,
    input  logic            step,
    input  logic [CH_W-1:0] end_ch,
    output logic [CH_W-1:0] ch
);
    typedef struct packed {
        logic [CH_W-1:0] ch;
    } idx_t;

    idx_t i_q, i_d;

    always_comb begin
        i_d = i_q;
        if (restart) begin
            i_d.ch = '0;
        end else if (en && step) begin
            if (i_q.ch >= end_ch) begin
                i_d.ch = '0;
            end else begin
                i_d.ch = i_q.ch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign ch = i_q.ch;
endmodule

// File: rtl/scan_result.sv
module scan_result #(
    parameter int CH_W   = 4,
    parameter int DATA_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [DATA_W-1:0]      sample,
    input  logic [CH_W-1:0]        tag,
    input  logic                   take,
    input  logic                   clr,
    output logic [CH_W+DATA_W-1:0] word,
    output logic                   valid,
    output logic                   overrun
);
    typedef struct packed {
        logic [CH_W+DATA_W-1:0] word;
        logic                   valid;
        logic                   ovr;
    } res_t;

    res_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.valid = 1'b0;
        end
        if (clr) begin
            s_d.ovr = 1'b0;
        end
        if (capture) begin
            s_d.word  = {tag, sample};
            s_d.valid = 1'b1;
            if (s_q.valid && !take) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word    = s_q.word;
    assign valid   = s_q.valid;
    assign overrun = s_q.ovr;
endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int GAIN_W = 2,
    parameter int DATA_W = 12,
    parameter int BUS_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [$clog2(NUM_CH):0]   addr,
    input  logic [BUS_W-1:0]          wdata,
    output logic [BUS_W-1:0]          rdata,
    input  logic                      conv_done,
    input  logic [DATA_W-1:0]         conv_data,
    output logic [$clog2(NUM_CH)-1:0] mux_ch,
    output logic [GAIN_W-1:0]         pga_gain,
    output logic                      overrun
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = CH_W + 1;
    localparam int RES_W  = CH_W + DATA_W;

    logic                          en, en_rise, ovr_clr, rd_take, res_valid;
    logic [CH_W-1:0]               end_ch, ch_idx;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_tab;
    logic [RES_W-1:0]              res_word;

    scan_regs #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .en(en), .en_rise(en_rise), .ovr_clr(ovr_clr), .end_ch(end_ch),
        .gain_tab(gain_tab)
    );

    scan_index #(.CH_W(CH_W)) u_index (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(en_rise),
        .step(conv_done), .end_ch(end_ch), .ch(ch_idx)
    );

    assign mux_ch   = en ? ch_idx : '0;
    assign pga_gain = gain_tab[mux_ch];
    assign rd_take  = rd_en && (addr == ADDR_W'(REG_RESULT));

    scan_result #(.CH_W(CH_W), .DATA_W(DATA_W)) u_result (
        .clk(clk), .rst_n(rst_n), .capture(conv_done), .sample(conv_data),
        .tag(mux_ch), .take(rd_take), .clr(ovr_clr), .word(res_word),
        .valid(res_valid), .overrun(overrun)
    );

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1]) begin
            rdata[GAIN_W-1:0] = gain_tab[addr[CH_W-1:0]];
        end else if (addr == ADDR_W'(REG_CTRL)) begin
            rdata[CTRL_EN]  = en;
            rdata[CTRL_OVR] = overrun;
        end else if (addr == ADDR_W'(REG_END)) begin
            rdata[CH_W-1:0] = end_ch;
        end else if (addr == ADDR_W'(REG_RESULT)) begin
            rdata[RES_W-1:0] = res_word;
        end
    end
endmodule

module scan_seq_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            en_rise,
    input logic            ovr_clr,
    input logic            conv_done,
    input logic            rd_take,
    input logic            res_valid,
    input logic            overrun,
    input logic [CH_W-1:0] end_ch,
    input logic [CH_W-1:0] mux_ch
);
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && conv_done && (mux_ch < end_ch)) |=> (!en || (mux_ch == CH_W'($past(mux_ch) + 1'b1))));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !conv_done) |=> (!en || (mux_ch == $past(mux_ch))));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && conv_done && (mux_ch >= end_ch)) |=> (mux_ch == '0));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (mux_ch == '0));

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && res_valid && !rd_take) |=> overrun);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

bind scan_seq scan_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .en_rise(en_rise), .ovr_clr(ovr_clr),
    .conv_done(conv_done), .rd_take(rd_take), .res_valid(res_valid),
    .overrun(overrun), .end_ch(end_ch), .mux_ch(mux_ch)
);

// File: tb/scan_seq_test.sv
module scan_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, conv_done = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [11:0] conv_data = '0;
    logic [3:0]  mux_ch;
    logic [1:0]  pga_gain;
    logic        overrun;

    int total = 0;
    int bad = 0;
    logic [5:0] exp_q[$];
    logic [1:0] gtab[16];
    logic [3:0] m_ch, m_end;
    logic       m_en;
    logic [15:0] m_res;

    always #10 clk = ~clk;

    scan_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .conv_done(conv_done),
        .conv_data(conv_data), .mux_ch(mux_ch), .pga_gain(pga_gain),
        .overrun(overrun)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a == 5'd0) begin
            if (d[0] && !m_en) m_ch = '0;
            m_en = d[0];
        end
        if (a == 5'd1) m_end = d[3:0];
        if (a[4]) gtab[a[3:0]] = d[1:0];
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // drive one strobe, optionally with a result read in the same cycle
    task automatic strobe(input logic [11:0] data, input logic with_read, output logic [15:0] old);
        logic [3:0] c;
        c = m_en ? m_ch : 4'd0;
        exp_q.push_back({c, gtab[c]});
        @(negedge clk);
        conv_done = 1'b1; conv_data = data;
        rd_en = with_read; addr = 5'd2;
        #1 old = rdata;
        @(posedge clk); #1;
        conv_done = 1'b0; rd_en = 1'b0;
        m_res = {c, data};
        if (m_en) m_ch = (m_ch >= m_end) ? 4'd0 : m_ch + 4'd1;
    endtask

    task automatic strobe_read(input logic [11:0] data);
        logic [15:0] v, junk;
        strobe(data, 1'b0, junk);
        rd(5'd2, v);
        check("R7 result tag/data", v, m_res);
    endtask

    // monitor: compares the presented channel and gain at every strobe
    always @(negedge clk) begin
        #5;
        if (conv_done) begin
            if (exp_q.size() == 0) begin
                check("R2 R4 unexpected strobe", 16'd1, 16'd0);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                check("R2 R3 R5 channel", {12'd0, mux_ch}, {12'd0, e[5:2]});
                check("R4 gain", {14'd0, pga_gain}, {14'd0, e[1:0]});
            end
        end
    end

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, old;
        m_ch = '0; m_end = '0; m_en = 1'b0; m_res = '0;
        for (int k = 0; k < 16; k++) gtab[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 mux_ch", {12'd0, mux_ch}, 16'd0);
        check("R1 gain", {14'd0, pga_gain}, 16'd0);
        check("R1 overrun", {15'd0, overrun}, 16'd0);
        rd(5'd0, v);
        check("R1 ctrl", v, 16'd0);

        // program table and end; R10 readback
        for (int k = 0; k < 16; k++) wr(5'd16 + 5'(k), 16'((k ^ (k >> 2)) & 3));
        wr(5'd1, 16'd3);
        rd(5'd1, v);
        check("R10 end readback", v, 16'd3);
        for (int k = 0; k < 16; k++) begin
            rd(5'd16 + 5'(k), v);
            check("R10 gain readback", v, {14'd0, gtab[k]});
        end

        // R5 disabled: strobes hold channel 0
        for (int i = 0; i < 3; i++) strobe_read(12'h100 + 12'(i));

        // R2 R3 scan with end=3
        wr(5'd0, 16'd1);
        for (int i = 0; i < 10; i++) strobe_read(12'h200 + 12'(i));
        check("R8 no overrun when read in time", {15'd0, overrun}, 16'd0);

        // R6 re-enable mid scan restarts at 0
        strobe_read(12'h300);
        wr(5'd0, 16'd0);
        @(negedge clk);
        check("R5 disabled channel", {12'd0, mux_ch}, 16'd0);
        check("R5 disabled gain", {14'd0, pga_gain}, {14'd0, gtab[0]});
        wr(5'd0, 16'd1);
        @(negedge clk);
        check("R6 restart channel", {12'd0, mux_ch}, 16'd0);
        strobe_read(12'h301);

        // R3 lowering end below current channel wraps on next strobe
        strobe_read(12'h302);
        strobe_read(12'h303);
        wr(5'd1, 16'd1);
        strobe_read(12'h304);
        @(negedge clk);
        check("R3 wrap after end lowered", {12'd0, mux_ch}, 16'd0);

        // R3 full range end=15
        wr(5'd1, 16'd15);
        wr(5'd0, 16'd0);
        wr(5'd0, 16'd1);
        for (int i = 0; i < 18; i++) strobe_read(12'h400 + 12'(i));

        // R3 end=0 stays on channel 0
        wr(5'd1, 16'd0);
        for (int i = 0; i < 3; i++) strobe_read(12'h500 + 12'(i));

        // R8 overrun on unread result
        wr(5'd1, 16'd3);
        strobe(12'h600, 1'b0, old);
        check("R8 no overrun on first", {15'd0, overrun}, 16'd0);
        strobe(12'h601, 1'b0, old);
        check("R8 overrun set", {15'd0, overrun}, 16'd1);
        rd(5'd0, v);
        check("R8 ctrl overrun bit", v, 16'd3);
        rd(5'd2, v);
        check("R7 latest result kept", v, m_res);

        // R9 sticky, write-one-to-clear
        wr(5'd0, 16'd1);
        check("R9 write 0 keeps flag", {15'd0, overrun}, 16'd1);
        wr(5'd0, 16'd3);
        check("R9 write 1 clears flag", {15'd0, overrun}, 16'd0);
        rd(5'd0, v);
        check("R9 enable kept", v, 16'd1);

        // R8 read in same cycle as strobe counts as read
        strobe(12'h700, 1'b0, old);
        v = m_res;
        strobe(12'h701, 1'b1, old);
        check("R7 old result during same-cycle read", old, v);
        check("R8 same-cycle read no overrun", {15'd0, overrun}, 16'd0);
        rd(5'd2, v);
        check("R7 new result", v, m_res);

        repeat (4) @(negedge clk);
        check("R2 R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule